// File: doc/BRIEF.md
# Programmable Parallel CRC Checker

Receive-side integrity checker for a 32-bit-per-cycle word stream. Each packet opens with a start marker and closes with an end marker. The word that carries the end marker holds the 16-bit check value in its low half. All earlier words of the packet go through a parallel CRC update, one word per cycle. Each update multiplies the concatenation of the running state and the data word by a 16-row GF(2) matrix held in writable registers. A different polynomial can be loaded at run time without changing the logic.

When the end word arrives, the block XORs the recomputed CRC with the received one. Any nonzero bit in the result raises a one-cycle error pulse. The stream itself is copied to the output one cycle later, unchanged, so the pulse lines up with the end word on the output side.

A bypass input suppresses checking. An inject input forces the error path, so the downstream handling can be tested.

Top module: `crc_checker`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, err_o and out_valid_o are 0.
- R2: out_valid_o, out_sop_o, out_eop_o and out_data_o equal in_valid_i, in_sop_i, in_eop_i and in_data_i from one clock earlier, whatever bypass_i and inject_i are.
- R3: With the reset matrix, a packet passes with err_o = 0 when the low 16 bits of its end word equal the CRC of its earlier words. That CRC starts from 16'hFFFF and uses polynomial 16'h1021. Bits go in MSB first, bit 31 of each word first, with feedback from state bit 15 and no reflection or final XOR. Bits 31:16 of the end word are ignored.
- R4: If the low 16 bits of the end word differ from the recomputed CRC in any bit, err_o is 1 in the cycle after the end word is accepted.
- R5: err_o is a single-cycle pulse. It is 1 only in the cycle directly after an accepted word with in_eop_i = 1.
- R6: If bypass_i = 1 while the end word is accepted, err_o stays 0 whatever the CRC comparison gives.
- R7: If inject_i = 1 and bypass_i = 0 while the end word is accepted, err_o is 1 even when the CRC matches.
- R8: Writing mat_wdata_i to row mat_addr_i with mat_we_i = 1 replaces the update for state bit mat_addr_i. That next bit becomes the parity of mat_wdata_i AND {data[31:0], state[15:0]}: bits 15:0 select state bits and bits 47:16 select data bits. A full matrix for polynomial 16'h8005 makes packets protected with that polynomial pass.
- R9: A packet with only one word, where start and end fall on the same cycle, compares its low 16 bits against the initial value 16'hFFFF.
- R10: Cycles with in_valid_i = 0 neither advance the CRC state nor raise err_o, including such gaps inside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input word valid |
| in_sop_i | input | 1 | First word of packet |
| in_eop_i | input | 1 | Last word of packet (carries the CRC) |
| in_data_i | input | 32 | Input data word |
| bypass_i | input | 1 | Suppress checking |
| inject_i | input | 1 | Force an error report |
| mat_we_i | input | 1 | Matrix row write enable |
| mat_addr_i | input | 4 | Matrix row index |
| mat_wdata_i | input | 48 | Matrix row mask |
| out_valid_o | output | 1 | Delayed valid |
| out_sop_o | output | 1 | Delayed start marker |
| out_eop_o | output | 1 | Delayed end marker |
| out_data_o | output | 32 | Delayed data word |
| err_o | output | 1 | One-cycle CRC error pulse |

## Verification
The hardest case to reach from the ports is a correct check after the matrix has been reprogrammed. It needs all 16 rows written coherently and then packets carrying CRCs for the new polynomial. The bench builds each row by pushing unit vectors through its own bit-serial model and writes them through the row port. It then sends random packets protected by the new polynomial. Random idle gaps, including gaps with stray end markers inside packets, and single-word packets exercise the framing corners.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_CRC_W  = 16;
  localparam logic [15:0] DEF_POLY   = 16'h1021;
  localparam logic [15:0] DEF_INIT   = 16'hFFFF;
endpackage

// File: rtl/crc_matrix_store.sv
module crc_matrix_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = '0,
  localparam int unsigned ROW_W = DATA_W + CRC_W,
  localparam int unsigned AW    = $clog2(CRC_W)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [ROW_W-1:0]            wdata_i,
  output logic [CRC_W-1:0][ROW_W-1:0] mat_o
);
  typedef logic [CRC_W-1:0][ROW_W-1:0] mat_t;

  // symbolic serial run: each state bit tracked as a mask over {data, state}
  function automatic mat_t build_mat(logic [CRC_W-1:0] poly);
    mat_t s;
    logic [ROW_W-1:0] fb;
    for (int k = 0; k < CRC_W; k++) s[k] = ROW_W'(1) << k;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = s[CRC_W-1] ^ (ROW_W'(1) << (CRC_W + i));
      for (int k = CRC_W - 1; k > 0; k--) s[k] = s[k-1];
      s[0] = '0;
      for (int k = 0; k < CRC_W; k++) if (poly[k]) s[k] = s[k] ^ fb;
    end
    return s;
  endfunction

  localparam mat_t DEF_MAT = build_mat(POLY);

  mat_t mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= DEF_MAT;
    else if (we_i && (32'(addr_i) < CRC_W)) mem_q[addr_i] <= wdata_i;
  end

  assign mat_o = mem_q;

  assert_row_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/crc_step.sv
module crc_step #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 16,
  localparam int unsigned ROW_W = DATA_W + CRC_W
) (
  input  logic [CRC_W-1:0][ROW_W-1:0] mat_i,
  input  logic [CRC_W-1:0]            state_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [CRC_W-1:0]            next_o
);
  logic [ROW_W-1:0] vec;
  assign vec = {data_i, state_i};

  for (genvar r = 0; r < CRC_W; r++) begin : g_row
    assign next_o[r] = ^(mat_i[r] & vec);
  end
endmodule

// File: rtl/crc_frame_check.sv
module crc_frame_check #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] INIT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [CRC_W-1:0] rx_crc_i,
  input  logic             bypass_i,
  input  logic             inject_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] base_o,
  output logic             err_o
);
  logic [CRC_W-1:0] crc_q;
  logic             err_q;
  logic [CRC_W-1:0] diff;

  assign base_o = sop_i ? INIT : crc_q;
  assign diff   = base_o ^ rx_crc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= INIT;
      err_q <= 1'b0;
    end else begin
      err_q <= valid_i && eop_i && !bypass_i && (inject_i || (|diff));
      if (valid_i && !eop_i) crc_q <= next_i;
    end
  end

  assign err_o = err_q;

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q));
  assert_err_after_eop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(valid_i && eop_i));
  assert_no_err_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !$past(bypass_i));
  assert_inject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eop_i && inject_i && !bypass_i) |=> err_q);
endmodule

// File: rtl/crc_checker.sv
module crc_checker
  import crc_chk_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CRC_W  = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY = CRC_W'(DEF_POLY),
  parameter logic [CRC_W-1:0] INIT = CRC_W'(DEF_INIT),
  localparam int unsigned ROW_W = DATA_W + CRC_W,
  localparam int unsigned AW    = $clog2(CRC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              bypass_i,
  input  logic              inject_i,
  input  logic              mat_we_i,
  input  logic [AW-1:0]     mat_addr_i,
  input  logic [ROW_W-1:0]  mat_wdata_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  logic [CRC_W-1:0][ROW_W-1:0] mat;
  logic [CRC_W-1:0]            base, next;

  crc_matrix_store #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_store (
    .clk_i, .rst_ni, .we_i(mat_we_i), .addr_i(mat_addr_i),
    .wdata_i(mat_wdata_i), .mat_o(mat)
  );

  crc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_step (
    .mat_i(mat), .state_i(base), .data_i(in_data_i), .next_o(next)
  );

  crc_frame_check #(.CRC_W(CRC_W), .INIT(INIT)) u_check (
    .clk_i, .rst_ni, .valid_i(in_valid_i), .sop_i(in_sop_i), .eop_i(in_eop_i),
    .rx_crc_i(in_data_i[CRC_W-1:0]), .bypass_i, .inject_i,
    .next_i(next), .base_o(base), .err_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      out_sop_o   <= in_sop_i;
      out_eop_o   <= in_eop_i;
      out_data_o  <= in_data_i;
    end
  end

  assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (out_valid_o == $past(in_valid_i)) && (out_data_o == $past(in_data_i)) &&
             (out_eop_o == $past(in_eop_i)) && (out_sop_o == $past(in_sop_i)));
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !err_o && !out_valid_o);
endmodule

// File: tb/crc_checker_tb.sv
module crc_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_sop = 0, in_eop = 0, bypass = 0, inject = 0;
  logic [31:0] in_data = '0;
  logic        mat_we = 0;
  logic [3:0]  mat_addr = '0;
  logic [47:0] mat_wdata = '0;
  logic        out_valid, out_sop, out_eop, err;
  logic [31:0] out_data;

  int unsigned n_chk = 0, n_bad = 0;
  logic [15:0] poly_m = 16'h1021;

  always #2 clk = ~clk;

  crc_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sop_i(in_sop),
    .in_eop_i(in_eop), .in_data_i(in_data), .bypass_i(bypass), .inject_i(inject),
    .mat_we_i(mat_we), .mat_addr_i(mat_addr), .mat_wdata_i(mat_wdata),
    .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_data_o(out_data), .err_o(err)
  );

  function automatic logic [15:0] ser(logic [15:0] c, logic [31:0] d, logic [15:0] p);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one cycle, check outputs right after the capturing edge
  task automatic cyc(logic v, logic s, logic e, logic [31:0] d, logic byp, logic inj,
                     logic exp_err, string req);
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; in_data = d; bypass = byp; inject = inj;
    @(posedge clk); #1;
    check("R2 pass", {out_valid, out_sop, out_eop, out_data}, {v, s, e, d});
    check(req, err, exp_err);
  endtask

  task automatic pkt(int n, logic corrupt, logic byp, logic inj, logic gaps);
    logic [15:0] c = 16'hFFFF;
    logic [31:0] w, cw;
    logic [15:0] flip;
    for (int i = 0; i < n; i++) begin
      w = $urandom;
      cyc(1, i == 0, 0, w, $urandom, $urandom, 0, "R5 no err mid-packet");
      c = ser(c, w, poly_m);
      if (gaps && $urandom_range(0, 2) == 0)
        cyc(0, $urandom, $urandom, $urandom, 0, $urandom, 0, "R10 idle gap");
    end
    flip = corrupt ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
    cw = {16'($urandom), c ^ flip};
    cyc(1, n == 0, 1, cw, byp, inj, !byp && (corrupt || inj),
        byp ? "R6 bypass" : (inj ? "R7 inject" : (corrupt ? "R4 mismatch" : "R3 clean")));
    cyc(0, 0, 0, 0, 0, 0, 0, "R5 single-cycle pulse");
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] col [48];
    logic [47:0] row;
    void'($urandom(32'd4242));
    #1;
    check("R1 reset err", err, 0);
    check("R1 reset valid", out_valid, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 first cycle err", err, 0);
    check("R1 first cycle valid", out_valid, 0);

    cyc(1, 1, 1, 32'hABCD_FFFF, 0, 0, 0, "R9 single-word match");
    cyc(1, 1, 1, 32'h0000_FFFE, 0, 0, 1, "R9 single-word mismatch");
    cyc(0, 0, 0, 0, 0, 0, 0, "R5 pulse ends");
    pkt(3, 0, 0, 0, 0);
    pkt(3, 1, 0, 0, 0);
    pkt(2, 0, 0, 1, 0);
    pkt(2, 1, 1, 0, 0);
    pkt(4, 0, 0, 0, 1);
    for (int k = 0; k < 60; k++)
      pkt($urandom_range(0, 6), $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
          $urandom_range(0, 7) == 0, $urandom);

    // R8: load matrix for polynomial 8005 through the row port
    poly_m = 16'h8005;
    for (int j = 0; j < 48; j++)
      col[j] = (j < 16) ? ser(16'(1 << j), 32'h0, poly_m) : ser(16'h0, 32'(1) << (j - 16), poly_m);
    for (int r = 0; r < 16; r++) begin
      for (int j = 0; j < 48; j++) row[j] = col[j][r];
      @(negedge clk);
      mat_we = 1; mat_addr = 4'(r); mat_wdata = row;
    end
    @(negedge clk); mat_we = 0;
    pkt(3, 0, 0, 0, 0);
    pkt(3, 1, 0, 0, 0);
    for (int k = 0; k < 30; k++)
      pkt($urandom_range(0, 6), $urandom_range(0, 3) == 0, 0, 0, $urandom);
    check("R8 reprogrammed", n_bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule